// File: doc/BRIEF.md
# Effective Address and Branch Unit

This block sits in the execute stage of a small processor with a 14-bit address space and 32 general registers. For every load, store or jump instruction it forms the memory or jump target address from the instruction's address field and an optional index register, and for jumps it decides from the status flags whether the branch is taken. Its outputs are the effective address, a taken indication and the next program counter value: the target for a taken jump, otherwise the current PC plus one.

Indexing needs no separate mode bits. The index register number travels in the instruction, and number zero is reserved to mean direct addressing. The value the register file presents for register zero is then not used. The same address computation serves loads, stores and jumps. Results are registered and appear one clock after an accepted request.

Top module: `eab_unit`

## Requirements
- R1: When `idx_sel` is 0, `eff_addr` equals `addr_field`.
- R2: When `idx_sel` is not 0, `eff_addr` equals `addr_field + idx_val` modulo 2^14.
- R3: When `idx_sel` is 0, the value on `idx_val` has no effect on `eff_addr`, `taken` or `next_pc`.
- R4: A jump with `cond` = 0 is always taken.
- R5: A jump with `cond` 1, 2, 3 or 4 is taken exactly when the flag C, N, V or Z respectively is 1. The flag bits are `flags[0]`=C, `flags[1]`=N, `flags[2]`=V and `flags[3]`=Z.
- R6: A jump with `cond` 5, 6, 7 or 8 is taken exactly when the flag C, N, V or Z respectively is 0.
- R7: A jump with `cond` from 9 to 15 is never taken.
- R8: When `taken` is 1, `next_pc` equals `eff_addr`, for both direct and indexed targets.
- R9: When `taken` is 0, `next_pc` equals `pc + 1` modulo 2^14, so PC 0x3FFF is followed by 0x0000.
- R10: When `is_jump` is 0, `taken` is 0 whatever `cond` and `flags` are.
- R11: All outputs are registered. `out_valid` rises one cycle after `in_valid`, and the results of that request appear in the same cycle. When `in_valid` is low, `out_valid` is 0 in the next cycle and the data outputs hold their values. Reset sets all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| is_jump | input | 1 | Request is a jump (0 = load or store) |
| addr_field | input | 14 | Address field of the instruction |
| idx_sel | input | 5 | Index register number, 0 = direct |
| idx_val | input | 14 | Value of the selected index register |
| pc | input | 14 | Current program counter |
| flags | input | 4 | Status flags {Z,V,N,C} |
| cond | input | 4 | Jump condition code |
| out_valid | output | 1 | Results below belong to a request |
| eff_addr | output | 14 | Effective address / jump target |
| taken | output | 1 | Jump taken |
| next_pc | output | 14 | Next program counter |

## Verification
Two functions can land in the same cycle: the indexed address addition, which can wrap past 0x3FFF, and the branch decision that routes that sum to `next_pc`. The bench applies indexed jumps whose sum wraps, under conditions that are met and conditions that are not, and in the same vectors places the PC at 0x3FFF. It then checks that `next_pc` follows the wrapped target when the jump is taken and the wrapped PC increment when it is not. Expected values come from a separate integer model that uses modulo arithmetic and decodes conditions by flag name.

// File: rtl/eab_pkg.sv
package eab_pkg;
  localparam int unsigned EAB_AW    = 14;
  localparam int unsigned EAB_SELW  = 5;
  localparam int unsigned EAB_CW    = 4;
  localparam int unsigned EAB_NFLAG = 4;

  // Condition code groups: ALWAYS, then one "set" code per flag, then one "clear" code per flag
  localparam logic [EAB_CW-1:0] COND_ALWAYS    = 4'd0;
  localparam logic [EAB_CW-1:0] COND_SET_BASE  = 4'd1;
  localparam logic [EAB_CW-1:0] COND_CLR_BASE  = 4'd1 + 4'(EAB_NFLAG);
  localparam logic [EAB_CW-1:0] COND_LAST_USED = 4'(2 * EAB_NFLAG);

  // flag bit positions
  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_N = 1;
  localparam int unsigned FLAG_V = 2;
  localparam int unsigned FLAG_Z = 3;
endpackage

// File: rtl/eab_addr_gen.sv
module eab_addr_gen #(
  parameter int unsigned AW   = 14,
  parameter int unsigned SELW = 5
) (
  input  logic [AW-1:0]   addr_field,
  input  logic [SELW-1:0] idx_sel,
  input  logic [AW-1:0]   idx_val,
  output logic            direct_mode,
  output logic [AW-1:0]   ea
);
  localparam logic [SELW-1:0] DIRECT_SEL = '0;

  // modulo-2^AW sum; the carry out is simply dropped
  function automatic logic [AW-1:0] f_ea(input logic [AW-1:0] base,
                                         input logic [AW-1:0] offs,
                                         input logic          is_direct);
    logic [AW:0] sum;
    sum = {1'b0, base} + {1'b0, (is_direct ? '0 : offs)};
    return sum[AW-1:0];
  endfunction

  assign direct_mode = (idx_sel == DIRECT_SEL);
  assign ea          = f_ea(addr_field, idx_val, direct_mode);

  // R1: direct mode passes the field through unchanged
  always_comb begin
    if (direct_mode) a_direct_r1: assert (ea == addr_field);
  end
endmodule

// File: rtl/eab_cond_eval.sv
module eab_cond_eval
  import eab_pkg::*;
#(
  parameter int unsigned CW    = EAB_CW,
  parameter int unsigned NFLAG = EAB_NFLAG
) (
  input  logic             is_jump,
  input  logic [CW-1:0]    cond,
  input  logic [NFLAG-1:0] flags,
  output logic             cond_met,
  output logic             take
);
  logic [NFLAG-1:0] set_hit;
  logic [NFLAG-1:0] clr_hit;
  logic             always_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NFLAG; gi++) begin : g_flag
      assign set_hit[gi] = (cond == CW'(COND_SET_BASE + gi)) &&  flags[gi];
      assign clr_hit[gi] = (cond == CW'(COND_CLR_BASE + gi)) && !flags[gi];
    end
  endgenerate

  assign always_hit = (cond == CW'(COND_ALWAYS));
  assign cond_met   = always_hit | (|set_hit) | (|clr_hit);
  assign take       = is_jump & cond_met;

  // set and clear matches are exclusive for any single code
  always_comb begin
    a_onehit_r6: assert ($onehot0({always_hit, set_hit, clr_hit}));
  end
endmodule

// File: rtl/eab_pc_sel.sv
module eab_pc_sel #(
  parameter int unsigned AW = 14
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] target,
  input  logic          take,
  output logic [AW-1:0] seq_pc,
  output logic [AW-1:0] nxt
);
  function automatic logic [AW-1:0] f_inc(input logic [AW-1:0] v);
    return v + AW'(1);
  endfunction

  assign seq_pc = f_inc(pc);
  assign nxt    = take ? target : seq_pc;
endmodule

// File: rtl/eab_unit.sv
module eab_unit
  import eab_pkg::*;
#(
  parameter int unsigned AW    = EAB_AW,
  parameter int unsigned SELW  = EAB_SELW,
  parameter int unsigned CW    = EAB_CW,
  parameter int unsigned NFLAG = EAB_NFLAG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             is_jump,
  input  logic [AW-1:0]    addr_field,
  input  logic [SELW-1:0]  idx_sel,
  input  logic [AW-1:0]    idx_val,
  input  logic [AW-1:0]    pc,
  input  logic [NFLAG-1:0] flags,
  input  logic [CW-1:0]    cond,
  output logic             out_valid,
  output logic [AW-1:0]    eff_addr,
  output logic             taken,
  output logic [AW-1:0]    next_pc
);
  logic          direct_mode;
  logic [AW-1:0] ea_comb;
  logic          cond_met;
  logic          take_comb;
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] nxt_comb;

  eab_addr_gen #(.AW(AW), .SELW(SELW)) u_addr (
    .addr_field (addr_field),
    .idx_sel    (idx_sel),
    .idx_val    (idx_val),
    .direct_mode(direct_mode),
    .ea         (ea_comb)
  );

  eab_cond_eval #(.CW(CW), .NFLAG(NFLAG)) u_cond (
    .is_jump (is_jump),
    .cond    (cond),
    .flags   (flags),
    .cond_met(cond_met),
    .take    (take_comb)
  );

  eab_pc_sel #(.AW(AW)) u_pcsel (
    .pc    (pc),
    .target(ea_comb),
    .take  (take_comb),
    .seq_pc(seq_pc),
    .nxt   (nxt_comb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      eff_addr  <= '0;
      taken     <= 1'b0;
      next_pc   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        eff_addr <= ea_comb;
        taken    <= take_comb;
        next_pc  <= nxt_comb;
      end
    end
  end

  p_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && idx_sel == '0) |=> (eff_addr == $past(addr_field)));

  p_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && idx_sel != '0) |=> (eff_addr == AW'($past(addr_field) + $past(idx_val))));

  p_always_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_jump && cond == CW'(COND_ALWAYS)) |=> taken);

  p_setflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_jump && cond >= CW'(COND_SET_BASE) && cond < CW'(COND_CLR_BASE))
      |=> (taken == $past(flags[2'(cond - CW'(COND_SET_BASE))])));

  p_clrflag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_jump && cond >= CW'(COND_CLR_BASE) && cond <= CW'(COND_LAST_USED))
      |=> (taken == !$past(flags[2'(cond - CW'(COND_CLR_BASE))])));

  p_never_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond > CW'(COND_LAST_USED)) |=> !taken);

  p_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && taken) |-> (next_pc == eff_addr));

  p_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (taken || next_pc == AW'($past(pc) + AW'(1))));

  p_nojump_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_jump) |=> !taken);

  p_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(eff_addr) && $stable(next_pc) && $stable(taken)));

  // internal decision must agree with the staged select
  p_met_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_jump && cond_met && !direct_mode) |=> (taken && next_pc == eff_addr));
endmodule

// File: tb/eab_unit_bench.sv
`timescale 1ns/1ps
module eab_unit_bench;
  localparam int AW = 14;
  localparam int NV = 14;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            is_jump = 1'b0;
  logic [AW-1:0]   addr_field = '0;
  logic [4:0]      idx_sel = '0;
  logic [AW-1:0]   idx_val = '0;
  logic [AW-1:0]   pc = '0;
  logic [3:0]      flags = '0;
  logic [3:0]      cond = '0;
  logic            out_valid;
  logic [AW-1:0]   eff_addr;
  logic            taken;
  logic [AW-1:0]   next_pc;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  eab_unit u_eab_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_jump(is_jump),
    .addr_field(addr_field), .idx_sel(idx_sel), .idx_val(idx_val), .pc(pc),
    .flags(flags), .cond(cond), .out_valid(out_valid), .eff_addr(eff_addr),
    .taken(taken), .next_pc(next_pc)
  );

  // {jump, addr, sel, idxval, pc, flags{Z,V,N,C}, cond}
  localparam logic [55:0] VEC [NV] = '{
    {1'b0, 14'h0123, 5'd0,  14'h1111, 14'h0010, 4'b0000, 4'd0},  // R1 R3 R10
    {1'b0, 14'h0100, 5'd7,  14'h0020, 14'h0011, 4'b1111, 4'd1},  // R2 R10
    {1'b1, 14'h0200, 5'd0,  14'h3FFF, 14'h0012, 4'b0000, 4'd0},  // R4 R3 R8
    {1'b1, 14'h3FF0, 5'd31, 14'h0020, 14'h0013, 4'b0000, 4'd0},  // R2 wrap R8
    {1'b1, 14'h0300, 5'd0,  14'h0000, 14'h0014, 4'b0001, 4'd1},  // R5 C
    {1'b1, 14'h0300, 5'd0,  14'h0000, 14'h0015, 4'b1101, 4'd2},  // R5 N clear
    {1'b1, 14'h0301, 5'd3,  14'h0004, 14'h0016, 4'b0100, 4'd3},  // R5 V
    {1'b1, 14'h0302, 5'd0,  14'h0000, 14'h0017, 4'b1000, 4'd4},  // R5 Z
    {1'b1, 14'h0400, 5'd0,  14'h0000, 14'h0018, 4'b1110, 4'd5},  // R6 NC
    {1'b1, 14'h0400, 5'd0,  14'h0000, 14'h0019, 4'b0010, 4'd6},  // R6 NN fail
    {1'b1, 14'h3FFF, 5'd9,  14'h0003, 14'h3FFF, 4'b1011, 4'd7},  // R6 NV wrap R9
    {1'b1, 14'h3FFF, 5'd9,  14'h0003, 14'h3FFF, 4'b1000, 4'd8},  // R6 NZ not, R9 wrap
    {1'b1, 14'h0500, 5'd2,  14'h0001, 14'h0020, 4'b1111, 4'd9},  // R7
    {1'b1, 14'h0500, 5'd0,  14'h0001, 14'h0021, 4'b0000, 4'd15}  // R7
  };

  function automatic bit m_taken(bit j, logic [3:0] f, int c);
    bit fc, fn, fv, fz;
    fc = f[0]; fn = f[1]; fv = f[2]; fz = f[3];
    if (!j) return 0;
    case (c)
      0: return 1;
      1: return fc;   2: return fn;   3: return fv;   4: return fz;
      5: return !fc;  6: return !fn;  7: return !fv;  8: return !fz;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [55:0] v, string req);
    int ea, np;
    bit tk;
    @(negedge clk);
    in_valid = 1'b1;
    {is_jump, addr_field, idx_sel, idx_val, pc, flags, cond} = v;
    ea = (idx_sel == 0) ? int'(addr_field) : (int'(addr_field) + int'(idx_val)) % 16384;
    tk = m_taken(is_jump, flags, int'(cond));
    np = tk ? ea : (int'(pc) + 1) % 16384;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid R11"}, int'(out_valid), 1);
    chk({req, " ea R1/R2"}, int'(eff_addr), ea);
    chk({req, " taken R4-R7"}, int'(taken), int'(tk));
    chk({req, " npc R8/R9"}, int'(next_pc), np);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset valid", int'(out_valid), 0);
    chk("R11 reset ea", int'(eff_addr), 0);
    chk("R11 reset taken", int'(taken), 0);
    chk("R11 reset npc", int'(next_pc), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) apply(VEC[i], $sformatf("vec%0d", i));

    // R3: register 0 selected, two different index values give same result
    apply({1'b1, 14'h2222, 5'd0, 14'h0000, 14'h0040, 4'b0000, 4'd0}, "R3 a");
    apply({1'b1, 14'h2222, 5'd0, 14'h1ABC, 14'h0040, 4'b0000, 4'd0}, "R3 b");
    chk("R3 ea unaffected", int'(eff_addr), 'h2222);

    // R10: non-jump with an always code and every flag pattern
    for (int f = 0; f < 16; f++) begin
      apply({1'b0, 14'h0777, 5'd1, 14'h0001, 14'h0050, 4'(f), 4'd0}, "R10 nojump");
      chk("R10 not taken", int'(taken), 0);
    end

    // R5 R6 sweep over every flag pattern and every code
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        apply({1'b1, 14'h1000, 5'd4, 14'h3800, 14'h0100, 4'(f), 4'(c)}, "R5/R6/R7 sweep");

    // R11: idle cycle drops valid and holds data
    apply({1'b1, 14'h0ABC, 5'd0, 14'h0000, 14'h0001, 4'b0000, 4'd0}, "R11 pre");
    @(negedge clk);
    chk("R11 idle valid", int'(out_valid), 0);
    chk("R11 hold ea", int'(eff_addr), 'h0ABC);
    chk("R11 hold npc", int'(next_pc), 'h0ABC);
    chk("R11 hold taken", int'(taken), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule